// File: doc/BRIEF.md
# Configuration-Space Target for a Parallel Local Bus

This block is a small bus target that answers only Type 0 configuration reads and writes on a 32-bit multiplexed address/data bus. On the clock where the frame signal is first seen low, it looks at the chip-select line for configuration, the command nibble and the low address bits. If the cycle is addressed to it, the block claims the cycle on the next clock and then completes exactly one data phase. Memory cycles, I/O cycles, parity, Type 1 cycles and arbitration are not handled.

Behind the bus logic there is a parameterised bank of 32-bit registers. A write updates only the byte lanes whose active-low enables are low. A read drives the addressed register onto the bus. Every target-driven signal has its own output enable: the claim strobe, the ready strobe, the stop strobe and the data bus. All enables are low from reset until the block claims a cycle.

Top module: `cfg_target`

## Requirements
- R1: While `rst_n` is low, `devsel_oe`, `trdy_oe`, `stop_oe` and `ad_oe` are all low. Reset is asynchronous.
- R2: An address phase is a rising edge with `frame_n` low that follows an edge with `frame_n` high, while the block is idle. The cycle is claimed only if, at that edge, `idsel` is 1, `cbe_n` is 4'b1010 (read) or 4'b1011 (write), and `ad_in[1:0]` is 2'b00. Otherwise all enables stay low.
- R3: The clock after a claimed address phase, `devsel_n_out` and `trdy_n_out` are both driven low (their enables are high).
- R4: The data phase completes at the first rising edge where `irdy_n` is low. For the following clock, `devsel_n_out`, `trdy_n_out` and `stop_n_out` are driven high. On the clock after that, all enables are low.
- R5: On a read, `ad_out` carries the addressed register. `ad_oe` is high only while `trdy_n_out` is driven low in a read.
- R6: On a write, at the completion edge, byte lane i (`ad_in[8i+7:8i]`) of the addressed register is written only if `cbe_n[i]` is low. The other lanes keep their values.
- R7: While the ready strobe is asserted, `stop_n_out` is low exactly when `frame_n` and `irdy_n` are both low. This is a burst attempt, and the block answers with a disconnect with data.
- R8: The register index is `ad_in[7:2]` from the address phase. An index of `NUM_REGS` or above reads as zero, and writes to it change no register.
- R9: All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data |
| ad_oe | output | 1 | Enable for the read data onto the bus |
| devsel_n_out | output | 1 | Claim strobe value, active low |
| devsel_oe | output | 1 | Claim strobe enable |
| trdy_n_out | output | 1 | Target ready value, active low |
| trdy_oe | output | 1 | Target ready enable |
| stop_n_out | output | 1 | Stop strobe value, active low |
| stop_oe | output | 1 | Stop strobe enable |

## Verification
The bench uses the default `NUM_REGS` = 4. With that value, all four implemented registers can be written and read back. Indices from 4 up to 63 fall outside the bank, so the read-as-zero and ignored-write rule can be exercised without changing any parameter. A small bank also keeps the reference model in the bench to four words. This lets each byte-enable pattern and each rejected cycle be checked by reading back a register that was set earlier.

// File: rtl/cfg_target.sv
module cfg_target #(
  parameter int NUM_REGS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n_out,
  output logic        devsel_oe,
  output logic        trdy_n_out,
  output logic        trdy_oe,
  output logic        stop_n_out,
  output logic        stop_oe
);
  localparam int IDX_W = 6;
  localparam int LANES = 4;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TURN} st_t;

  st_t              st;
  logic             frame_q;
  logic             wr_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      regs [NUM_REGS];
  logic [31:0]      rd_data;

  wire addr_phase = (st == S_IDLE) && frame_q && !frame_n;
  wire hit        = addr_phase && idsel && (cbe_n[3:1] == 3'b101) && (ad_in[1:0] == 2'b00);
  wire done       = (st == S_DATA) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b1;
      wr_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE: if (hit) begin
          st    <= S_DATA;
          wr_q  <= cbe_n[0];
          idx_q <= ad_in[7:2];
        end
        S_DATA: if (done) st <= S_TURN;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[r] <= '0;
      end else if (done && wr_q && idx_q == IDX_W'(r)) begin
        for (int b = 0; b < LANES; b++)
          if (!cbe_n[b]) regs[r][8*b +: 8] <= ad_in[8*b +: 8];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx_q == IDX_W'(r)) rd_data = regs[r];
  end

  assign ad_out       = rd_data;
  assign ad_oe        = (st == S_DATA) && !wr_q;
  assign devsel_oe    = (st != S_IDLE);
  assign trdy_oe      = (st != S_IDLE);
  assign stop_oe      = (st != S_IDLE);
  assign devsel_n_out = (st != S_DATA);
  assign trdy_n_out   = (st != S_DATA);
  assign stop_n_out   = !((st == S_DATA) && !frame_n && !irdy_n);
endmodule

module cfg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       idsel,
  input logic [3:0] cbe_n,
  input logic [1:0] ad_lo,
  input logic       ad_oe,
  input logic       devsel_n_out,
  input logic       devsel_oe,
  input logic       trdy_n_out,
  input logic       trdy_oe,
  input logic       stop_n_out,
  input logic       stop_oe
);
  logic frame_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_seen <= 1'b1;
    else        frame_seen <= frame_n;

  wire start   = !devsel_oe && frame_seen && !frame_n;
  wire sel_ok  = idsel && (cbe_n == 4'b1010 || cbe_n == 4'b1011) && ad_lo == 2'b00;
  wire ready   = trdy_oe && !trdy_n_out;

  a_r1_reset_float: assert property (@(posedge clk)
    !rst_n |-> !devsel_oe && !trdy_oe && !stop_oe && !ad_oe);

  a_r2_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel_ok) |=> !devsel_oe);

  a_r3_fast_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel_ok) |=> (devsel_oe && !devsel_n_out && ready));

  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !irdy_n) |=> (trdy_oe && trdy_n_out && devsel_n_out && stop_n_out));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && trdy_n_out) |=> !trdy_oe && !devsel_oe && !stop_oe);

  a_r5_data_window: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ready);

  a_r7_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (stop_n_out == !(!frame_n && !irdy_n)));
endmodule

bind cfg_target cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
  .cbe_n(cbe_n), .ad_lo(ad_in[1:0]), .ad_oe(ad_oe),
  .devsel_n_out(devsel_n_out), .devsel_oe(devsel_oe),
  .trdy_n_out(trdy_n_out), .trdy_oe(trdy_oe),
  .stop_n_out(stop_n_out), .stop_oe(stop_oe)
);

// File: tb/sim_cfg_target.sv
module sim_cfg_target;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n_out, devsel_oe, trdy_n_out, trdy_oe, stop_n_out, stop_oe;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;
  logic [31:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_target #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n_out(devsel_n_out), .devsel_oe(devsel_oe),
    .trdy_n_out(trdy_n_out), .trdy_oe(trdy_oe),
    .stop_n_out(stop_n_out), .stop_oe(stop_oe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit wr, input int idx, input bit sel, input logic [3:0] cmd,
                           input logic [1:0] lo, input logic [31:0] data, input logic [3:0] be,
                           input bit burst, input int waits, input bit claim,
                           output logic [31:0] rd);
    rd = '0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; idsel = sel; cbe_n = cmd;
    ad_in = {24'h0, 6'(idx), lo};
    @(negedge clk);
    idsel = 1'b0;
    if (!claim) begin
      check("R2 no claim", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
      frame_n = 1'b1; irdy_n = 1'b0; cbe_n = be; ad_in = data;
      @(negedge clk);
      check("R2 still idle", {devsel_oe, trdy_oe, stop_oe}, 3'b000);
      irdy_n = 1'b1;
      return;
    end
    check("R3 claim next clock", {devsel_oe, devsel_n_out, trdy_oe, trdy_n_out}, 4'b1010);
    cbe_n = be; ad_in = wr ? data : 32'h0;
    for (int w = 0; w < waits; w++) begin
      #1;
      check("R4 wait keeps ready", {trdy_oe, trdy_n_out, stop_n_out}, 3'b101);
      @(negedge clk);
    end
    irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1;
    #1;
    check("R7 stop value", stop_n_out, burst ? 1'b0 : 1'b1);
    check("R5 data enable", ad_oe, !wr);
    rd = ad_out;
    @(negedge clk);
    check("R4 turnaround high", {devsel_oe, devsel_n_out, trdy_oe, trdy_n_out, stop_oe, stop_n_out, ad_oe},
          7'b1111110);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    check("R4 released", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
  endtask

  task automatic cfg_write(int idx, logic [31:0] data, logic [3:0] be, bit burst);
    logic [31:0] d;
    bus_cycle(1'b1, idx, 1'b1, 4'b1011, 2'b00, data, be, burst, 0, 1'b1, d);
    if (idx < NREG)
      for (int b = 0; b < 4; b++) if (!be[b]) model[idx][8*b +: 8] = data[8*b +: 8];
  endtask

  task automatic cfg_read_check(string req, int idx, int waits);
    logic [31:0] d;
    bus_cycle(1'b0, idx, 1'b1, 4'b1010, 2'b00, 32'h0, 4'h0, 1'b0, waits, 1'b1, d);
    check(req, d, idx < NREG ? model[idx] : 32'h0);
  endtask

  task automatic t_reset;
    check("R1 enables low in reset", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
  endtask

  task automatic t_reset_values;
    for (int r = 0; r < NREG; r++) cfg_read_check("R9 reset value", r, 0);
  endtask

  task automatic t_full_write;
    cfg_write(1, 32'hA5A5_1234, 4'b0000, 1'b0);
    cfg_write(3, 32'hDEAD_BEEF, 4'b0000, 1'b0);
    cfg_read_check("R5 read reg1", 1, 0);
    cfg_read_check("R5 read reg3", 3, 0);
  endtask

  task automatic t_byte_enables;
    cfg_write(1, 32'hFFFF_FFFF, 4'b1010, 1'b0);
    check("R6 model lanes", model[1], 32'hA5FF_12FF);
    cfg_read_check("R6 lanes 0 and 2 only", 1, 0);
    cfg_write(3, 32'h0000_0000, 4'b0111, 1'b0);
    cfg_read_check("R6 lane 3 only", 3, 0);
  endtask

  task automatic t_out_of_range;
    cfg_write(9, 32'h1234_5678, 4'b0000, 1'b0);
    cfg_read_check("R8 unimplemented reads zero", 9, 0);
    for (int r = 0; r < NREG; r++) cfg_read_check("R8 write ignored", r, 0);
  endtask

  task automatic t_rejects;
    logic [31:0] d;
    bus_cycle(1'b1, 0, 1'b0, 4'b1011, 2'b00, 32'h1111_1111, 4'h0, 1'b0, 0, 1'b0, d);
    bus_cycle(1'b1, 0, 1'b1, 4'b0111, 2'b00, 32'h2222_2222, 4'h0, 1'b0, 0, 1'b0, d);
    bus_cycle(1'b1, 0, 1'b1, 4'b1011, 2'b01, 32'h3333_3333, 4'h0, 1'b0, 0, 1'b0, d);
    cfg_read_check("R2 rejected cycles left reg0", 0, 0);
  endtask

  task automatic t_burst_and_wait;
    cfg_write(2, 32'hC0FF_EE00, 4'b0000, 1'b1);
    cfg_read_check("R7 disconnect wrote data", 2, 0);
    cfg_read_check("R4 read with wait states", 2, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    #(CLK_PERIOD * 2 + 2);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset_values;
    t_full_write;
    t_byte_enables;
    t_out_of_range;
    t_rejects;
    t_burst_and_wait;
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule